// File: doc/BRIEF.md
# Hamming Single-Error-Correcting Byte Codec

This block protects one data byte with a 12-bit Hamming code that corrects any single-bit error. It has two independent stream channels. The encode channel turns a byte into a 12-bit codeword with no clock delay. The check channel takes a stored or transmitted codeword that may be corrupted. From it the check channel derives a 4-bit syndrome, repairs the single bit the syndrome names, and returns the byte together with error flags one cycle later.

Codeword positions are counted from 1 at the leftmost bit, which is the MSB of the 12-bit port. Check bits sit at positions 1, 2, 4 and 8. The data bits fill positions 3, 5, 6, 7, 9, 10, 11 and 12, in order. On the byte ports, data bit D1 is bit 7 and D8 is bit 0.

Both channels use valid/ready handshakes. A transfer happens on a clock edge where valid and ready are both high. The encode channel is a pure combinational path, so its input ready is the downstream ready. The check channel has a one-entry output register. It accepts a new word whenever that register is empty or is being drained in the same cycle. While its output is stalled, the register holds its contents and the channel refuses input.

Top module: `hamming_sec_codec`

## Requirements
- R1: The encoder places check bits P1, P2, P4, P8 at positions 1, 2, 4, 8 and data bits D1..D8 at positions 3, 5, 6, 7, 9, 10, 11, 12, where position 1 is bit 11 of `enc_out_word` and D1 is bit 7 of `enc_in_data`. Data 8'h9A encodes to 12'h72A.
- R2: Each check bit makes even parity over itself and the positions whose index has the matching binary weight set. P1 covers D1 D2 D4 D5 D7, P2 covers D1 D3 D4 D6 D7, P4 covers D2 D3 D4 D8, and P8 covers D5 D6 D7 D8. This holds for all 256 data values.
- R3: When the check channel receives a valid codeword, it reports syndrome 0, `chk_out_err`=0, `chk_out_uncorr`=0, and the original byte.
- R4: When exactly one bit at position p (1..12) is inverted, the channel reports syndrome p and `chk_out_err`=1, and `chk_out_data` holds the original byte. This includes the case where p is a check-bit position.
- R5: The syndrome bits are ordered (P8,P4,P2,P1), from bit 3 down to bit 0. A syndrome of 13..15 sets both `chk_out_err` and `chk_out_uncorr`, and the data bits of the received word pass through unaltered.
- R6: A word accepted on a clock edge appears on the check outputs, with `chk_out_valid` high, right after that same edge.
- R7: `chk_in_ready` is high when the output register is empty or `chk_out_ready` is high. While `chk_out_valid` is high and `chk_out_ready` is low, all check outputs hold steady and no new word is taken.
- R8: The encode channel is combinational. `enc_out_valid` follows `enc_in_valid`, `enc_in_ready` follows `enc_out_ready`, and `enc_out_word` reflects the present `enc_in_data`.
- R9: After reset, `chk_out_valid` is 0 and `chk_in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enc_in_valid | input | 1 | Byte to encode is present |
| enc_in_ready | output | 1 | Encoder can take the byte |
| enc_in_data | input | 8 | Byte to encode, D1 at bit 7 |
| enc_out_valid | output | 1 | Codeword is present |
| enc_out_ready | input | 1 | Downstream takes the codeword |
| enc_out_word | output | 12 | Codeword, position 1 at bit 11 |
| chk_in_valid | input | 1 | Received word is present |
| chk_in_ready | output | 1 | Checker can take the word |
| chk_in_word | input | 12 | Received word, position 1 at bit 11 |
| chk_out_valid | output | 1 | Check result is present |
| chk_out_ready | input | 1 | Downstream takes the result |
| chk_out_data | output | 8 | Corrected byte |
| chk_out_syndrome | output | 4 | Syndrome (P8,P4,P2,P1) |
| chk_out_err | output | 1 | Syndrome nonzero |
| chk_out_uncorr | output | 1 | Syndrome names no existing position |

## Verification
The bench encodes every byte value and compares the result against independently written parity groups. A wrong bit order or a misplaced check bit therefore shows up as a codeword mismatch on the worked example or on many values. Each clean codeword is then sent through the checker, followed by every single-bit corruption of it, including corruptions of the check bits themselves. A design that reversed the syndrome weighting or repaired the wrong position would return a wrong byte or a wrong syndrome for those cases. Double-bit patterns whose syndrome is 13 to 15 are sent to confirm that the data bits pass through untouched and the uncorrectable flag rises; a design that wrapped the syndrome into a valid position would corrupt an extra bit. A stalled output is held while a second word is offered, which catches a register that is overwritten or a ready signal that ignores back-pressure.

// File: rtl/hsec_pkg.sv
package hsec_pkg;

  // Smallest number of check bits r with 2**r >= data_w + r + 1.
  function automatic int par_width(input int data_w);
    int r;
    r = 1;
    while ((1 << r) < data_w + r + 1) r++;
    return r;
  endfunction

  function automatic bit is_pow2(input int p);
    return (p > 0) && ((p & (p - 1)) == 0);
  endfunction

endpackage

// File: rtl/hsec_encoder.sv
module hsec_encoder #(
  parameter int DATA_W = 8,
  localparam int PAR_W = hsec_pkg::par_width(DATA_W),
  localparam int CW_W  = DATA_W + PAR_W
) (
  input  logic [DATA_W-1:0] data_i,
  output logic [CW_W-1:0]   word_o
);
  // Position p (1-based from the left) lives at bit CW_W-p.
  logic [CW_W-1:0] placed;

  always_comb begin
    int k;
    placed = '0;
    k = 1;
    for (int p = 1; p <= CW_W; p++) begin
      if (!hsec_pkg::is_pow2(p)) begin
        placed[CW_W-p] = data_i[DATA_W-k];
        k++;
      end
    end
  end

  always_comb begin
    word_o = placed;
    for (int j = 0; j < PAR_W; j++) begin
      logic acc;
      acc = 1'b0;
      for (int p = 1; p <= CW_W; p++) begin
        if (((p >> j) & 1) == 1) acc ^= placed[CW_W-p];
      end
      word_o[CW_W-(1 << j)] = acc;
    end
  end
endmodule

// File: rtl/hsec_syndrome.sv
module hsec_syndrome #(
  parameter int DATA_W = 8,
  localparam int PAR_W = hsec_pkg::par_width(DATA_W),
  localparam int CW_W  = DATA_W + PAR_W
) (
  input  logic [CW_W-1:0]  word_i,
  output logic [PAR_W-1:0] syn_o
);
  genvar j;
  generate
    for (j = 0; j < PAR_W; j++) begin : g_grp
      always_comb begin
        logic acc;
        acc = 1'b0;
        for (int p = 1; p <= CW_W; p++) begin
          if (((p >> j) & 1) == 1) acc ^= word_i[CW_W-p];
        end
        syn_o[j] = acc;
      end
    end
  endgenerate
endmodule

// File: rtl/hsec_corrector.sv
module hsec_corrector #(
  parameter int DATA_W = 8,
  localparam int PAR_W = hsec_pkg::par_width(DATA_W),
  localparam int CW_W  = DATA_W + PAR_W
) (
  input  logic [CW_W-1:0]   word_i,
  input  logic [PAR_W-1:0]  syn_i,
  output logic [DATA_W-1:0] data_o,
  output logic              err_o,
  output logic              uncorr_o
);
  logic [CW_W-1:0] fixed_w;

  assign err_o    = (syn_i != '0);
  assign uncorr_o = (int'(syn_i) > CW_W);

  // Invert only the position the syndrome names; out-of-range names flip nothing.
  always_comb begin
    fixed_w = word_i;
    for (int p = 1; p <= CW_W; p++) begin
      if (int'(syn_i) == p) fixed_w[CW_W-p] = ~word_i[CW_W-p];
    end
  end

  always_comb begin
    int k;
    data_o = '0;
    k = 1;
    for (int p = 1; p <= CW_W; p++) begin
      if (!hsec_pkg::is_pow2(p)) begin
        data_o[DATA_W-k] = fixed_w[CW_W-p];
        k++;
      end
    end
  end
endmodule

// File: rtl/hamming_sec_codec.sv
module hamming_sec_codec #(
  parameter int DATA_W = 8,
  localparam int PAR_W = hsec_pkg::par_width(DATA_W),
  localparam int CW_W  = DATA_W + PAR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enc_in_valid,
  output logic              enc_in_ready,
  input  logic [DATA_W-1:0] enc_in_data,
  output logic              enc_out_valid,
  input  logic              enc_out_ready,
  output logic [CW_W-1:0]   enc_out_word,
  input  logic              chk_in_valid,
  output logic              chk_in_ready,
  input  logic [CW_W-1:0]   chk_in_word,
  output logic              chk_out_valid,
  input  logic              chk_out_ready,
  output logic [DATA_W-1:0] chk_out_data,
  output logic [PAR_W-1:0]  chk_out_syndrome,
  output logic              chk_out_err,
  output logic              chk_out_uncorr
);
  // Encode channel: combinational pass-through.
  assign enc_out_valid = enc_in_valid;
  assign enc_in_ready  = enc_out_ready;

  hsec_encoder #(.DATA_W(DATA_W)) u_enc (
    .data_i (enc_in_data),
    .word_o (enc_out_word)
  );

  // Check channel: syndrome and repair ahead of a one-entry output register.
  logic [PAR_W-1:0]  syn_c;
  logic [DATA_W-1:0] data_c;
  logic              err_c, uncorr_c;

  hsec_syndrome #(.DATA_W(DATA_W)) u_syn (
    .word_i (chk_in_word),
    .syn_o  (syn_c)
  );

  hsec_corrector #(.DATA_W(DATA_W)) u_fix (
    .word_i   (chk_in_word),
    .syn_i    (syn_c),
    .data_o   (data_c),
    .err_o    (err_c),
    .uncorr_o (uncorr_c)
  );

  logic take;
  assign chk_in_ready = !chk_out_valid || chk_out_ready;
  assign take         = chk_in_valid && chk_in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chk_out_valid    <= 1'b0;
      chk_out_data     <= '0;
      chk_out_syndrome <= '0;
      chk_out_err      <= 1'b0;
      chk_out_uncorr   <= 1'b0;
    end else begin
      if (chk_in_ready) chk_out_valid <= chk_in_valid;
      if (take) begin
        chk_out_data     <= data_c;
        chk_out_syndrome <= syn_c;
        chk_out_err      <= err_c;
        chk_out_uncorr   <= uncorr_c;
      end
    end
  end

  AST_ACCEPT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    chk_in_valid && chk_in_ready |=> chk_out_valid); // R6

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    chk_out_valid && !chk_out_ready |=> chk_out_valid && $stable(chk_out_data)
      && $stable(chk_out_syndrome) && $stable(chk_out_err) && $stable(chk_out_uncorr)); // R7

  AST_EMPTY_READY: assert property (@(posedge clk) disable iff (!rst_n)
    !chk_out_valid |-> chk_in_ready); // R7

  AST_UNCORR_FLAGS_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    chk_out_valid && chk_out_uncorr |-> chk_out_err && (int'(chk_out_syndrome) > CW_W)); // R5
endmodule

// File: tb/hamming_sec_codec_tb_top.sv
module hamming_sec_codec_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        enc_in_valid = 0, enc_out_ready = 0;
  logic [7:0]  enc_in_data = 0;
  logic        enc_in_ready, enc_out_valid;
  logic [11:0] enc_out_word;
  logic        chk_in_valid = 0, chk_out_ready = 1;
  logic [11:0] chk_in_word = 0;
  logic        chk_in_ready, chk_out_valid, chk_out_err, chk_out_uncorr;
  logic [7:0]  chk_out_data;
  logic [3:0]  chk_out_syndrome;

  int total = 0, bad = 0;
  bit done = 0;

  hamming_sec_codec dut_i (.*);

  function automatic logic [11:0] ref_enc(input logic [7:0] d);
    logic d1, d2, d3, d4, d5, d6, d7, d8;
    {d1, d2, d3, d4, d5, d6, d7, d8} = d;
    return {d1 ^ d2 ^ d4 ^ d5 ^ d7, d1 ^ d3 ^ d4 ^ d6 ^ d7, d1,
            d2 ^ d3 ^ d4 ^ d8, d2, d3, d4,
            d5 ^ d6 ^ d7 ^ d8, d5, d6, d7, d8};
  endfunction

  function automatic logic [11:0] flip(input logic [11:0] w, input int p);
    return w ^ (12'h800 >> (p - 1));
  endfunction

  function automatic logic [7:0] raw_data(input logic [11:0] w);
    return {w[9], w[7], w[6], w[5], w[3], w[2], w[1], w[0]};
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Drive one word, sample the registered result after the next edge.
  task automatic send_word(input logic [11:0] w, input string req,
                           input logic [7:0] e_data, input logic [3:0] e_syn,
                           input bit e_err, input bit e_unc);
    @(negedge clk);
    chk_in_valid = 1; chk_in_word = w;
    @(negedge clk);
    chk_in_valid = 0;
    chk(chk_out_valid == 1, req, "valid", chk_out_valid, 1);
    chk(chk_out_data == e_data && chk_out_syndrome == e_syn &&
        chk_out_err == e_err && chk_out_uncorr == e_unc, req, "data/syn/err/unc",
        {chk_out_data, chk_out_syndrome, 3'b0, chk_out_err, 3'b0, chk_out_uncorr},
        {e_data, e_syn, 3'b0, e_err, 3'b0, e_unc});
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(chk_out_valid == 0, "R9", "out_valid after reset", chk_out_valid, 0);
    chk(chk_in_ready == 1, "R9", "in_ready after reset", chk_in_ready, 1);
  endtask

  task automatic t_encode();
    @(negedge clk);
    enc_in_valid = 1; enc_out_ready = 0; enc_in_data = 8'h9A;
    #1;
    chk(enc_out_word == 12'h72A, "R1", "example codeword", enc_out_word, 12'h72A);
    chk(enc_out_valid == 1 && enc_in_ready == 0, "R8", "handshake pass-through",
        {enc_out_valid, enc_in_ready}, 2'b10);
    enc_out_ready = 1; enc_in_valid = 0;
    #1;
    chk(enc_out_valid == 0 && enc_in_ready == 1, "R8", "handshake follow",
        {enc_out_valid, enc_in_ready}, 2'b01);
    for (int d = 0; d < 256; d++) begin
      enc_in_data = d[7:0];
      #1;
      chk(enc_out_word == ref_enc(d[7:0]), "R2", "codeword", enc_out_word, ref_enc(d[7:0]));
    end
  endtask

  task automatic t_clean_and_single();
    for (int d = 0; d < 256; d++) begin
      logic [11:0] w;
      w = ref_enc(d[7:0]);
      send_word(w, "R3", d[7:0], 4'd0, 0, 0);
      for (int p = 1; p <= 12; p++)
        send_word(flip(w, p), "R4", d[7:0], p[3:0], 1, 0);
    end
  endtask

  task automatic t_uncorrectable();
    int pairs[3][2] = '{'{1, 12}, '{2, 12}, '{3, 12}}; // syndromes 13, 14, 15
    for (int i = 0; i < 3; i++) begin
      logic [11:0] w;
      w = flip(flip(ref_enc(8'h5C), pairs[i][0]), pairs[i][1]);
      send_word(w, "R5", raw_data(w), 4'(pairs[i][0] ^ pairs[i][1]), 1, 1);
    end
  endtask

  task automatic t_backpressure();
    logic [11:0] w1, w2;
    w1 = ref_enc(8'h3C);
    w2 = flip(ref_enc(8'hC3), 5);
    @(negedge clk);
    chk_out_ready = 0; chk_in_valid = 1; chk_in_word = w1;
    @(negedge clk);
    chk(chk_out_valid == 1 && chk_out_data == 8'h3C, "R6", "one-cycle latency",
        chk_out_data, 8'h3C);
    chk_in_word = w2;
    #1;
    chk(chk_in_ready == 0, "R7", "ready low when stalled", chk_in_ready, 0);
    repeat (3) @(negedge clk);
    chk(chk_out_valid == 1 && chk_out_data == 8'h3C && chk_out_syndrome == 0,
        "R7", "held while stalled", chk_out_data, 8'h3C);
    chk_out_ready = 1;
    #1;
    chk(chk_in_ready == 1, "R7", "ready with drain", chk_in_ready, 1);
    @(negedge clk);
    chk_in_valid = 0;
    chk(chk_out_valid == 1 && chk_out_data == 8'hC3 && chk_out_syndrome == 4'd5,
        "R7", "second word after drain", {chk_out_data, chk_out_syndrome}, {8'hC3, 4'd5});
    @(negedge clk);
    chk(chk_out_valid == 0, "R7", "drained", chk_out_valid, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    t_reset();
    t_encode();
    t_clean_and_single();
    t_uncorrectable();
    t_backpressure();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired actual=hung expected=done");
      end
    join_any
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule